// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the purely combinational arithmetic/logic stage of a small integer datapath. It takes two operands of `WIDTH` bits and a 4-bit operation select. It returns a result word, a flag set when that result is all zeros, and a signed-overflow flag. It implements ten operations:

- add and subtract, each in a signed (trapping) form and an unsigned form
- the four bitwise functions AND, OR, XOR and NOR
- signed and unsigned less-than compares

Immediates reach it already extended. Multiply, divide, shifts and instruction decoding live elsewhere.

One adder serves every arithmetic operation. A subtract feeds the inverted second operand into that adder and sets the low carry-in to one. The two compares read the adder's flags, so equality tests (`a - b` with the zero flag) and both orderings share the same carry chain.

Top module: `int_alu`

## Requirements
- R1: Code 0 (add) and code 1 (addu) give `result = (a + b) mod 2^WIDTH`.
- R2: Code 2 (sub) and code 3 (subu) give `result = (a - b) mod 2^WIDTH`, formed as `a + ~b + 1`.
- R3: For code 0, `overflow` is 1 exactly when the signed sum of `a` and `b` lies outside the two's-complement range of `WIDTH` bits. This is the case when two non-negatives give a negative, or two negatives give a non-negative.
- R4: For code 2, `overflow` is 1 exactly when the signed difference `a - b` lies outside the two's-complement range. This is the case when a non-negative minus a negative gives a negative, or a negative minus a non-negative gives a non-negative.
- R5: `overflow` is 0 for every code other than 0 and 2, including addu and subu.
- R6: Code 4 gives `a & b`, code 5 gives `a | b`, code 6 gives `a ^ b`, and code 7 gives `~(a | b)`.
- R7: Code 0xA gives 1 in bit 0 when `a < b` as signed numbers, and 0 otherwise. All higher bits are 0. The answer is correct even when `a - b` overflows.
- R8: Code 0xB gives 1 in bit 0 when `a < b` as unsigned numbers, and 0 otherwise. All higher bits are 0.
- R9: The unused codes 8, 9 and 0xC to 0xF give a result of 0 and an overflow of 0.
- R10: `zero` is 1 exactly when `result` is all zeros, for every code. For codes 2 and 3 this means `zero` is 1 exactly when `a == b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| op | input | 4 | Operation select (encoding in R1 to R9) |
| result | output | WIDTH | Operation result |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow for codes 0 and 2 |

## Verification
The bench builds two copies of the block: one at the default `WIDTH` of 32 and one at `WIDTH` 8. At 32 bits, the directed corner operands (0, 1, all ones, the most positive value and the most negative value) expose the range limits a real datapath meets. At 8 bits, random operands land on signed overflow, on equal operands and on compares near the wrap points often enough to exercise those paths heavily. Every one of the sixteen codes, including the unused ones, is applied against a reference model that works on wide signed integers rather than on carries.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_ADDU = 4'h1,
        OP_SUB  = 4'h2,
        OP_SUBU = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_NOR  = 4'h7,
        OP_SLT  = 4'hA,
        OP_SLTU = 4'hB
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_fn_e;

    // Flags produced by the shared adder.
    typedef struct packed {
        logic sign;      // top bit of the sum
        logic carry_out; // carry leaving the top bit
        logic ovf;       // carry into top bit xor carry out of it
    } add_flags_t;

    // Arithmetic codes that run the adder in subtract mode.
    function automatic logic op_subtracts(input logic [3:0] code);
        return (code == OP_SUB) || (code == OP_SUBU) ||
               (code == OP_SLT) || (code == OP_SLTU);
    endfunction

    // Codes whose signed overflow is reported.
    function automatic logic op_traps(input logic [3:0] code);
        return (code == OP_ADD) || (code == OP_SUB);
    endfunction

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output add_flags_t       flags
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [TOP-1:0]   low_sum;
    logic             c_into_top;
    logic             top_bit;
    logic             c_out;

    assign b_eff = sub ? ~b : b;

    // Low part; the carry-in supplies the +1 of the two's-complement negate.
    assign {c_into_top, low_sum} = {1'b0, a[TOP-1:0]} + {1'b0, b_eff[TOP-1:0]}
                                 + {{TOP{1'b0}}, sub};

    // Top bit kept apart so both carries around it are visible.
    assign {c_out, top_bit} = {1'b0, a[TOP]} + {1'b0, b_eff[TOP]} + {1'b0, c_into_top};

    assign sum             = {top_bit, low_sum};
    assign flags.sign      = top_bit;
    assign flags.carry_out = c_out;
    assign flags.ovf       = c_into_top ^ c_out;

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        fn,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] either;

    assign either = a | b;

    always_comb begin
        unique case (fn)
            LG_AND:  y = a & b;
            LG_OR:   y = either;
            LG_XOR:  y = a ^ b;
            LG_NOR:  y = ~either;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/int_alu_cmp.sv
module int_alu_cmp
    import int_alu_pkg::*;
(
    input  add_flags_t flags,
    output logic       lt_signed,
    output logic       lt_unsigned
);
    // Sign of a-b corrected by the overflow: the true signed order.
    assign lt_signed   = flags.sign ^ flags.ovf;
    // No carry out of a + ~b + 1 means a borrow occurred.
    assign lt_unsigned = ~flags.carry_out;

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow
);
    localparam int PAD = WIDTH - 1;

    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] lg_y;
    add_flags_t       flags;
    logic             lt_s;
    logic             lt_u;

    int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a     (a),
        .b     (b),
        .sub   (op_subtracts(op)),
        .sum   (sum),
        .flags (flags)
    );

    int_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (a),
        .b  (b),
        .fn (logic_fn_e'(op[1:0])),
        .y  (lg_y)
    );

    int_alu_cmp u_cmp (
        .flags       (flags),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:    result = lg_y;
            OP_SLT:                           result = {{PAD{1'b0}}, lt_s};
            OP_SLTU:                          result = {{PAD{1'b0}}, lt_u};
            default:                          result = '0;
        endcase
    end

    assign overflow = op_traps(op) & flags.ovf;
    assign zero     = ~|result;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [3:0]       op,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow
);
    localparam int TOP = WIDTH - 1;

    always_comb begin
        // R5: overflow only ever reported for codes 0 and 2
        if (overflow === 1'b1)
            assert_ovf_codes_R5: assert (op == 4'h0 || op == 4'h2);

        // R9: unused codes give nothing
        if (op == 4'h8 || op == 4'h9 || op >= 4'hC)
            assert_unused_quiet_R9: assert (result == '0 && overflow == 1'b0);

        // R7 / R8: compares only drive bit 0
        if (op == 4'hA || op == 4'hB)
            assert_cmp_upper_R7: assert (result[TOP:1] == '0);

        // R10: subtract forms flag zero exactly on equal operands
        if (op == 4'h2 || op == 4'h3)
            assert_sub_zero_R10: assert (zero == (a == b));

        // R3: add overflow needs like-signed operands and a flipped sign
        if (op == 4'h0 && overflow === 1'b1)
            assert_add_ovf_sign_R3: assert (a[TOP] == b[TOP] && result[TOP] != a[TOP]);

        // R4: sub overflow needs unlike-signed operands and a sign unlike a
        if (op == 4'h2 && overflow === 1'b1)
            assert_sub_ovf_sign_R4: assert (a[TOP] != b[TOP] && result[TOP] != a[TOP]);
    end

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a        (a),
    .b        (b),
    .op       (op),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;

    localparam int W_WIDE   = 32;
    localparam int W_NARROW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10ns clk = ~clk; // 50 MHz

    logic [W_WIDE-1:0]   a32 = '0, b32 = '0, r32;
    logic [W_NARROW-1:0] a8  = '0, b8  = '0, r8;
    logic [3:0]          op32 = '0, op8 = '0;
    logic                z32, v32, z8, v8;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    int_alu #(.WIDTH(W_WIDE)) u_int_alu (
        .a(a32), .b(b32), .op(op32), .result(r32), .zero(z32), .overflow(v32)
    );

    int_alu #(.WIDTH(W_NARROW)) u_int_alu_narrow (
        .a(a8), .b(b8), .op(op8), .result(r8), .zero(z8), .overflow(v8)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'h0:       return "R1/R3";
            4'h1:       return "R1/R5";
            4'h2:       return "R2/R4";
            4'h3:       return "R2/R5";
            4'h4, 4'h5,
            4'h6, 4'h7: return "R6";
            4'hA:       return "R7";
            4'hB:       return "R8";
            default:    return "R9";
        endcase
    endfunction

    // Reference model on wide signed integers.
    function automatic void ref_alu(input int w, input logic [63:0] a, input logic [63:0] b,
                                    input logic [3:0] op,
                                    output logic [63:0] r, output logic v);
        logic [63:0] mask = (64'd1 << w) - 64'd1;
        longint sa, sb, t;
        longint maxv = (longint'(1) <<< (w - 1)) - 1;
        longint minv = -(longint'(1) <<< (w - 1));
        sa = longint'(a << (64 - w)); sa = sa >>> (64 - w);
        sb = longint'(b << (64 - w)); sb = sb >>> (64 - w);
        v = 1'b0;
        r = '0;
        case (op)
            4'h0, 4'h1: begin t = sa + sb; r = 64'(t) & mask; v = (op == 4'h0) && (t > maxv || t < minv); end
            4'h2, 4'h3: begin t = sa - sb; r = 64'(t) & mask; v = (op == 4'h2) && (t > maxv || t < minv); end
            4'h4: r = a & b;
            4'h5: r = a | b;
            4'h6: r = a ^ b;
            4'h7: r = ~(a | b) & mask;
            4'hA: r = (sa < sb) ? 64'd1 : 64'd0;
            4'hB: r = ((a & mask) < (b & mask)) ? 64'd1 : 64'd0;
            default: r = '0;
        endcase
    endfunction

    task automatic apply(input int w, input logic [63:0] a, input logic [63:0] b, input logic [3:0] op);
        logic [63:0] er, ar;
        logic ev, av, az;
        @(posedge clk);
        if (w == W_WIDE) begin a32 = a[W_WIDE-1:0]; b32 = b[W_WIDE-1:0]; op32 = op; end
        else             begin a8 = a[W_NARROW-1:0]; b8 = b[W_NARROW-1:0]; op8 = op; end
        @(negedge clk);
        ref_alu(w, a, b, op, er, ev);
        if (w == W_WIDE) begin ar = 64'(r32); av = v32; az = z32; end
        else             begin ar = 64'(r8);  av = v8;  az = z8;  end
        vectors++;
        if (ar !== er || av !== ev) begin
            fails++;
            $display("FAIL %s w=%0d op=%h a=%h b=%h: result=%h ovf=%b expected result=%h ovf=%b",
                     req_of(op), w, op, a, b, ar, av, er, ev);
        end else if (az !== (er == 0)) begin
            fails++;
            $display("FAIL R10 w=%0d op=%h a=%h b=%h: zero=%b expected %b", w, op, a, b, az, (er == 0));
        end
    endtask

    initial begin
        logic [63:0] corners [5];
        int w;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: all-zero inputs, add gives 0 with zero set (R1, R10)
        @(negedge clk);
        vectors++;
        if (r32 !== '0 || z32 !== 1'b1 || v32 !== 1'b0) begin
            fails++;
            $display("FAIL R10 idle: result=%h zero=%b ovf=%b expected 0/1/0", r32, z32, v32);
        end
        for (int k = 0; k < 2; k++) begin
            w = (k == 0) ? W_WIDE : W_NARROW;
            corners[0] = 64'd0;
            corners[1] = 64'd1;
            corners[2] = (64'd1 << w) - 64'd1;
            corners[3] = (64'd1 << (w - 1)) - 64'd1;
            corners[4] = 64'd1 << (w - 1);
            for (int o = 0; o < 16; o++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j++)
                        apply(w, corners[i], corners[j], 4'(o));
        end
        for (int n = 0; n < 3000; n++) begin
            apply(W_WIDE, {32'd0, $urandom}, {32'd0, $urandom}, 4'($urandom_range(0, 15)));
            apply(W_NARROW, 64'($urandom_range(0, 255)), 64'($urandom_range(0, 255)),
                  4'($urandom_range(0, 15)));
        end
        // Equal operands on subtract forms: zero must rise (R10)
        for (int n = 0; n < 50; n++) begin
            logic [63:0] x = 64'($urandom);
            apply(W_WIDE, x, x, 4'h2);
            apply(W_WIDE, x, x, 4'h3);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule